// File: doc/BRIEF.md
# Receive Acceptance Filter with Masks

This block decides where a received frame goes once reception on the bus has ended. A frame-complete strobe loads the frame identifier, its extended-format bit and its payload into a serial holding buffer. The identifier is then compared against every receive mailbox and against the filter of a receive FIFO. Each comparison uses either one global mask shared by all mailboxes or the mailbox's own mask, depending on the individual-masking mode. A mailbox takes part only when its code says it is an active receive mailbox, empty or full, and its extended-format bit equals the frame's.

When there is a winner, the block raises a one-cycle move-in strobe. This strobe stands for the intermission slot after the frame. It comes with the destination (FIFO or mailbox index), and the holding buffer contents are presented for the copy. The owner of the mailbox table writes the full code into the winning mailbox on that strobe. The winning mailbox's sticky interrupt flag is set at the same time. When nothing matches, the frame simply stays in the holding buffer until the next frame overwrites it. Acknowledging frames on the bus does not depend on this block.

Top module: `rx_accept_filter`

## Requirements
- R1: A cycle with `frameDone` high loads `frameId`, `frameIde` and `frameData` into the holding buffer. From the next cycle, `bufId`, `bufIde` and `bufData` show these values and keep them until the next `frameDone`.
- R2: `moveValid` is high for exactly one cycle, the second cycle after the cycle in which `frameDone` was high, and only if a winner exists.
- R3: When neither the FIFO nor any mailbox matches, `moveValid` stays low, `mbFlag` does not change and the holding buffer keeps the frame.
- R4: Mailbox i is a candidate only if its 4-bit code (`mbCode[4*i+3:4*i]`) is 4'h4 (receive, empty) or 4'h2 (receive, full), and `mbIde[i]` equals the frame's IDE bit.
- R5: With `indMaskEn` low, every mailbox compares under `globalMask`. With `indMaskEn` high, mailbox i compares under its own `mbMask[ID_W*i +: ID_W]`. A mask bit of 1 means the ID bit must be equal, so an all-ones mask demands an exact match.
- R6: Among matching candidate mailboxes, the lowest index wins and is reported on `moveIdx`.
- R7: When `fifoEn` is high, `fifoFull` is low and the frame passes the FIFO filter, the FIFO wins over all mailboxes. The FIFO filter is `fifoId`/`fifoIde` under `fifoMask` in individual mode and under `globalMask` otherwise. In that case `moveFifo` is high, `moveIdx` is 0 and no mailbox flag is set.
- R8: When the FIFO is full or its filter does not match, the frame still goes to the lowest-indexed matching mailbox.
- R9: `mbFlag[i]` is set on the clock edge that ends a move-in cycle into mailbox i and stays set. A 1 on `flagClr[i]` clears it, except in the cycle where the same bit is being set, where the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameDone | input | 1 | Frame received without error, one-cycle strobe |
| frameId | input | ID_W | Identifier of the received frame |
| frameIde | input | 1 | Extended-format bit of the received frame |
| frameData | input | DATA_W | Payload of the received frame |
| mbCode | input | 4*NUM_MB | Code field per mailbox |
| mbId | input | ID_W*NUM_MB | Filter identifier per mailbox |
| mbIde | input | NUM_MB | Extended-format bit per mailbox |
| mbMask | input | ID_W*NUM_MB | Individual mask per mailbox |
| globalMask | input | ID_W | Shared mask |
| indMaskEn | input | 1 | Selects individual masks |
| fifoEn | input | 1 | FIFO takes part in matching |
| fifoFull | input | 1 | FIFO has no room |
| fifoId | input | ID_W | FIFO filter identifier |
| fifoIde | input | 1 | FIFO filter extended-format bit |
| fifoMask | input | ID_W | FIFO mask in individual mode |
| flagClr | input | NUM_MB | Write-one-to-clear for mailbox flags |
| moveValid | output | 1 | Move-in strobe |
| moveFifo | output | 1 | Move-in targets the FIFO |
| moveIdx | output | IDX_W | Winning mailbox index |
| bufId | output | ID_W | Holding buffer identifier |
| bufIde | output | 1 | Holding buffer extended-format bit |
| bufData | output | DATA_W | Holding buffer payload |
| mbFlag | output | NUM_MB | Sticky interrupt flag per mailbox |

## Verification
A flag being set by a move-in and a software clear of the flags can fall on the same clock edge. The bench provokes this by driving `flagClr` with all ones during the move-in cycle. It then expects only the winner's flag to survive while every other flag is cleared. FIFO-versus-mailbox priority is also decided in the same cycle. This is provoked by making the FIFO filter and a mailbox both match, with the FIFO state toggled between full and not full, and judged by `moveFifo`, `moveIdx` and the flags.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [3:0] CODE_RX_EMPTY = 4'h4;
  localparam logic [3:0] CODE_RX_FULL  = 4'h2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MATCH = 2'd1,
    ST_MOVE  = 2'd2
  } rxfState_t;

  typedef struct packed {
    logic capture;
    logic latchWin;
    logic move;
  } rxfCtl_t;
endpackage

// File: rtl/rxf_match_lane.sv
module rxf_match_lane #(
  parameter int ID_W = 29
) (
  input  logic [ID_W-1:0] candId,
  input  logic            candIde,
  input  logic [ID_W-1:0] refId,
  input  logic            refIde,
  input  logic [ID_W-1:0] mask,
  input  logic [3:0]      code,
  input  logic            checkCode,
  output logic            hit
);
  import rxf_pkg::*;

  logic codeOk;
  logic idOk;

  always_comb begin
    codeOk = !checkCode || (code == CODE_RX_EMPTY) || (code == CODE_RX_FULL);
    idOk   = (((candId ^ refId) & mask) == '0);
    hit    = codeOk && idOk && (candIde == refIde);
  end
endmodule

// File: rtl/rxf_control.sv
module rxf_control (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameDone,
  output rxf_pkg::rxfCtl_t ctl
);
  import rxf_pkg::*;

  rxfState_t stateQ;
  rxfState_t stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (frameDone) stateD = ST_MATCH;
      ST_MATCH: stateD = ST_MOVE;
      ST_MOVE:  stateD = frameDone ? ST_MATCH : ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    ctl.capture  = frameDone;
    ctl.latchWin = (stateQ == ST_MATCH);
    ctl.move     = (stateQ == ST_MOVE);
  end
endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath #(
  parameter int NUM_MB = 8,
  parameter int ID_W   = 29,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rxf_pkg::rxfCtl_t       ctl,
  input  logic [ID_W-1:0]        frameId,
  input  logic                   frameIde,
  input  logic [DATA_W-1:0]      frameData,
  input  logic [4*NUM_MB-1:0]    mbCode,
  input  logic [ID_W*NUM_MB-1:0] mbId,
  input  logic [NUM_MB-1:0]      mbIde,
  input  logic [ID_W*NUM_MB-1:0] mbMask,
  input  logic [ID_W-1:0]        globalMask,
  input  logic                   indMaskEn,
  input  logic                   fifoEn,
  input  logic                   fifoFull,
  input  logic [ID_W-1:0]        fifoId,
  input  logic                   fifoIde,
  input  logic [ID_W-1:0]        fifoMask,
  input  logic [NUM_MB-1:0]      flagClr,
  output logic                   moveValid,
  output logic                   moveFifo,
  output logic [IDX_W-1:0]       moveIdx,
  output logic [ID_W-1:0]        bufId,
  output logic                   bufIde,
  output logic [DATA_W-1:0]      bufData,
  output logic [NUM_MB-1:0]      mbFlag
);
  // Holding buffer
  logic [ID_W-1:0]   bufIdQ;
  logic              bufIdeQ;
  logic [DATA_W-1:0] bufDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufIdQ   <= '0;
      bufIdeQ  <= 1'b0;
      bufDataQ <= '0;
    end else if (ctl.capture) begin
      bufIdQ   <= frameId;
      bufIdeQ  <= frameIde;
      bufDataQ <= frameData;
    end
  end

  // Comparison lanes, one per mailbox
  logic [NUM_MB-1:0] mbHit;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_lane
    logic [ID_W-1:0] laneMask;
    assign laneMask = indMaskEn ? mbMask[ID_W*g +: ID_W] : globalMask;
    rxf_match_lane #(.ID_W(ID_W)) lane_i (
      .candId   (bufIdQ),
      .candIde  (bufIdeQ),
      .refId    (mbId[ID_W*g +: ID_W]),
      .refIde   (mbIde[g]),
      .mask     (laneMask),
      .code     (mbCode[4*g +: 4]),
      .checkCode(1'b1),
      .hit      (mbHit[g])
    );
  end

  // FIFO filter lane
  logic            fifoHit;
  logic [ID_W-1:0] fifoLaneMask;
  assign fifoLaneMask = indMaskEn ? fifoMask : globalMask;

  rxf_match_lane #(.ID_W(ID_W)) fifoLane_i (
    .candId   (bufIdQ),
    .candIde  (bufIdeQ),
    .refId    (fifoId),
    .refIde   (fifoIde),
    .mask     (fifoLaneMask),
    .code     (4'h0),
    .checkCode(1'b0),
    .hit      (fifoHit)
  );

  // Lowest index wins
  logic             anyMb;
  logic [IDX_W-1:0] firstIdx;

  always_comb begin
    anyMb    = 1'b0;
    firstIdx = '0;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (mbHit[i]) begin
        anyMb    = 1'b1;
        firstIdx = IDX_W'(i);
      end
    end
  end

  logic fifoTake;
  assign fifoTake = fifoEn && !fifoFull && fifoHit;

  // Winner register
  logic             winHitQ;
  logic             winFifoQ;
  logic [IDX_W-1:0] winIdxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winHitQ  <= 1'b0;
      winFifoQ <= 1'b0;
      winIdxQ  <= '0;
    end else if (ctl.latchWin) begin
      winHitQ  <= fifoTake || anyMb;
      winFifoQ <= fifoTake;
      winIdxQ  <= fifoTake ? '0 : firstIdx;
    end
  end

  // Move-in and flags
  logic              moveNow;
  logic [NUM_MB-1:0] setVec;

  assign moveNow = ctl.move && winHitQ;

  always_comb begin
    setVec = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (moveNow && !winFifoQ && (winIdxQ == IDX_W'(i))) setVec[i] = 1'b1;
    end
  end

  logic [NUM_MB-1:0] flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~flagClr) | setVec;
  end

  assign moveValid = moveNow;
  assign moveFifo  = moveNow && winFifoQ;
  assign moveIdx   = winIdxQ;
  assign bufId     = bufIdQ;
  assign bufIde    = bufIdeQ;
  assign bufData   = bufDataQ;
  assign mbFlag    = flagQ;
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter #(
  parameter int NUM_MB = 8,
  parameter int ID_W   = 29,
  parameter int DATA_W = 64,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameDone,
  input  logic [ID_W-1:0]        frameId,
  input  logic                   frameIde,
  input  logic [DATA_W-1:0]      frameData,
  input  logic [4*NUM_MB-1:0]    mbCode,
  input  logic [ID_W*NUM_MB-1:0] mbId,
  input  logic [NUM_MB-1:0]      mbIde,
  input  logic [ID_W*NUM_MB-1:0] mbMask,
  input  logic [ID_W-1:0]        globalMask,
  input  logic                   indMaskEn,
  input  logic                   fifoEn,
  input  logic                   fifoFull,
  input  logic [ID_W-1:0]        fifoId,
  input  logic                   fifoIde,
  input  logic [ID_W-1:0]        fifoMask,
  input  logic [NUM_MB-1:0]      flagClr,
  output logic                   moveValid,
  output logic                   moveFifo,
  output logic [IDX_W-1:0]       moveIdx,
  output logic [ID_W-1:0]        bufId,
  output logic                   bufIde,
  output logic [DATA_W-1:0]      bufData,
  output logic [NUM_MB-1:0]      mbFlag
);
  rxf_pkg::rxfCtl_t ctl;

  rxf_control control_i (
    .clk      (clk),
    .rstN     (rstN),
    .frameDone(frameDone),
    .ctl      (ctl)
  );

  rxf_datapath #(
    .NUM_MB(NUM_MB), .ID_W(ID_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .frameId   (frameId),
    .frameIde  (frameIde),
    .frameData (frameData),
    .mbCode    (mbCode),
    .mbId      (mbId),
    .mbIde     (mbIde),
    .mbMask    (mbMask),
    .globalMask(globalMask),
    .indMaskEn (indMaskEn),
    .fifoEn    (fifoEn),
    .fifoFull  (fifoFull),
    .fifoId    (fifoId),
    .fifoIde   (fifoIde),
    .fifoMask  (fifoMask),
    .flagClr   (flagClr),
    .moveValid (moveValid),
    .moveFifo  (moveFifo),
    .moveIdx   (moveIdx),
    .bufId     (bufId),
    .bufIde    (bufIde),
    .bufData   (bufData),
    .mbFlag    (mbFlag)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int NUM_MB = 8,
  parameter int ID_W   = 29,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                frameDone,
  input logic [4*NUM_MB-1:0] mbCode,
  input logic                fifoFull,
  input logic [NUM_MB-1:0]   flagClr,
  input logic                moveValid,
  input logic                moveFifo,
  input logic [IDX_W-1:0]    moveIdx,
  input logic [ID_W-1:0]     bufId,
  input logic [DATA_W-1:0]   bufData,
  input logic [NUM_MB-1:0]   mbFlag
);
  // R2: strobe only two cycles after a frame
  a_r2_move_after_frame: assert property (@(posedge clk) disable iff (!rstN)
    moveValid |-> $past(frameDone, 2));

  // R2: strobe lasts one cycle
  a_r2_move_single: assert property (@(posedge clk) disable iff (!rstN)
    moveValid |=> !moveValid);

  // R1: buffer steady across the move-in
  a_r1_buffer_held: assert property (@(posedge clk) disable iff (!rstN)
    moveValid |-> ($stable(bufId) && $stable(bufData)));

  // R4: a mailbox winner holds an active receive code
  a_r4_winner_code: assert property (@(posedge clk) disable iff (!rstN)
    (moveValid && !moveFifo) |->
      ((mbCode[4*moveIdx +: 4] == 4'h4) || (mbCode[4*moveIdx +: 4] == 4'h2)));

  // R7: a FIFO move-in needs room
  a_r7_fifo_room: assert property (@(posedge clk) disable iff (!rstN)
    (moveValid && moveFifo) |-> !$past(fifoFull));

  // R9: a flag rises only after a mailbox move-in, and only one at a time
  a_r9_flag_source: assert property (@(posedge clk) disable iff (!rstN)
    (|(mbFlag & ~$past(mbFlag))) |->
      ($past(moveValid) && !$past(moveFifo) && $onehot(mbFlag & ~$past(mbFlag))));

  // R7: FIFO move-in leaves flags to the clear input only
  a_r7_fifo_flagless: assert property (@(posedge clk) disable iff (!rstN)
    ($past(moveValid) && $past(moveFifo)) |->
      (mbFlag == ($past(mbFlag) & ~$past(flagClr))));
endmodule

bind rx_accept_filter rxf_checker #(
  .NUM_MB(NUM_MB), .ID_W(ID_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .frameDone(frameDone),
  .mbCode   (mbCode),
  .fifoFull (fifoFull),
  .flagClr  (flagClr),
  .moveValid(moveValid),
  .moveFifo (moveFifo),
  .moveIdx  (moveIdx),
  .bufId    (bufId),
  .bufData  (bufData),
  .mbFlag   (mbFlag)
);

// File: tb/rx_accept_filter_tb_top.sv
`timescale 1ns/1ps
module rx_accept_filter_tb_top;
  localparam int NUM_MB = 8;
  localparam int ID_W   = 29;
  localparam int DATA_W = 64;
  localparam int IDX_W  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic                   frameDone = 1'b0;
  logic [ID_W-1:0]        frameId = '0;
  logic                   frameIde = 1'b0;
  logic [DATA_W-1:0]      frameData = '0;
  logic [4*NUM_MB-1:0]    mbCode = '0;
  logic [ID_W*NUM_MB-1:0] mbId = '0;
  logic [NUM_MB-1:0]      mbIde = '0;
  logic [ID_W*NUM_MB-1:0] mbMask = '1;
  logic [ID_W-1:0]        globalMask = '1;
  logic                   indMaskEn = 1'b0;
  logic                   fifoEn = 1'b0;
  logic                   fifoFull = 1'b0;
  logic [ID_W-1:0]        fifoId = '0;
  logic                   fifoIde = 1'b0;
  logic [ID_W-1:0]        fifoMask = '1;
  logic [NUM_MB-1:0]      flagClr = '0;
  logic                   moveValid;
  logic                   moveFifo;
  logic [IDX_W-1:0]       moveIdx;
  logic [ID_W-1:0]        bufId;
  logic                   bufIde;
  logic [DATA_W-1:0]      bufData;
  logic [NUM_MB-1:0]      mbFlag;

  rx_accept_filter #(.NUM_MB(NUM_MB), .ID_W(ID_W), .DATA_W(DATA_W)) dut_i (.*);

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic [NUM_MB-1:0] expFlags = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit idMatch(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b,
                                 input logic [ID_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

  // Reference decision written from the requirements
  task automatic refPick(input logic [ID_W-1:0] id, input logic ide,
                         output bit hit, output bit fifo, output int idx);
    logic [ID_W-1:0] fm;
    hit = 0; fifo = 0; idx = 0;
    fm = indMaskEn ? fifoMask : globalMask;
    if (fifoEn && !fifoFull && (fifoIde == ide) && idMatch(id, fifoId, fm)) begin
      hit = 1; fifo = 1; return;
    end
    for (int i = 0; i < NUM_MB; i++) begin
      logic [3:0] c;
      logic [ID_W-1:0] m;
      c = mbCode[4*i +: 4];
      m = indMaskEn ? mbMask[ID_W*i +: ID_W] : globalMask;
      if ((c == 4'h4 || c == 4'h2) && mbIde[i] == ide && idMatch(id, mbId[ID_W*i +: ID_W], m)) begin
        hit = 1; idx = i; return;
      end
    end
  endtask

  task automatic sendFrame(input logic [ID_W-1:0] id, input logic ide,
                           input logic [DATA_W-1:0] data, input logic [NUM_MB-1:0] clrAtMove);
    bit hit, fifo;
    int idx;
    refPick(id, ide, hit, fifo, idx);
    @(negedge clk);
    frameDone = 1'b1; frameId = id; frameIde = ide; frameData = data;
    @(negedge clk);
    frameDone = 1'b0;
    @(negedge clk);
    chk("R2 moveValid", 64'(moveValid), 64'(hit));
    chk("R7 moveFifo", 64'(moveFifo), 64'(hit && fifo));
    if (hit) chk("R6 moveIdx", 64'(moveIdx), 64'(idx));
    chk("R1 bufId", 64'(bufId), 64'(id));
    chk("R1 bufData", bufData, data);
    flagClr = clrAtMove;
    expFlags = expFlags & ~clrAtMove;
    if (hit && !fifo) expFlags[idx] = 1'b1;
    @(negedge clk);
    flagClr = '0;
    chk("R2 strobe one cycle", 64'(moveValid), 64'd0);
    chk("R9 mbFlag", 64'(mbFlag), 64'(expFlags));
  endtask

  task automatic clearFlags();
    @(negedge clk);
    flagClr = '1;
    @(negedge clk);
    flagClr = '0;
    expFlags = '0;
  endtask

  task automatic resetTable();
    mbCode = '0; mbId = '0; mbIde = '0; mbMask = '1;
    globalMask = '1; indMaskEn = 1'b0; fifoEn = 1'b0; fifoFull = 1'b0;
    fifoId = '0; fifoIde = 1'b0; fifoMask = '1;
  endtask

  task automatic setMb(input int i, input logic [3:0] c, input logic [ID_W-1:0] id,
                       input logic ide, input logic [ID_W-1:0] m);
    mbCode[4*i +: 4] = c;
    mbId[ID_W*i +: ID_W] = id;
    mbIde[i] = ide;
    mbMask[ID_W*i +: ID_W] = m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog R2 actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R2 reset moveValid", 64'(moveValid), 64'd0);
    chk("R9 reset mbFlag", 64'(mbFlag), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R5: exact match under an all-ones individual mask
    resetTable();
    indMaskEn = 1'b1;
    setMb(2, 4'h4, 29'h123, 1'b0, '1);
    sendFrame(29'h123, 1'b0, 64'hA1, '0);
    // R3: one bit off misses, frame stays in buffer
    sendFrame(29'h124, 1'b0, 64'hB2, '0);
    repeat (4) @(negedge clk);
    chk("R3 buffer kept", 64'(bufId), 64'h124);
    chk("R3 flags kept", 64'(mbFlag), 64'(expFlags));
    // R5: global mask ignores low bits only when individual mode is off
    globalMask = ~29'h7;
    setMb(2, 4'h4, 29'h120, 1'b0, '1);
    indMaskEn = 1'b0;
    sendFrame(29'h125, 1'b0, 64'hC3, '0);
    indMaskEn = 1'b1;
    sendFrame(29'h125, 1'b0, 64'hC4, '0);
    // R6: tie goes to the lowest index
    clearFlags();
    indMaskEn = 1'b0;
    setMb(2, 4'h0, 29'h0, 1'b0, '1);
    setMb(3, 4'h2, 29'h300, 1'b0, '1);
    setMb(5, 4'h4, 29'h301, 1'b0, '1);
    sendFrame(29'h302, 1'b0, 64'hD5, '0);
    // R4: inactive code and IDE mismatch exclude a mailbox
    setMb(3, 4'h8, 29'h300, 1'b0, '1);
    sendFrame(29'h302, 1'b0, 64'hD6, '0);
    setMb(5, 4'h4, 29'h301, 1'b1, '1);
    sendFrame(29'h302, 1'b0, 64'hD7, '0);
    sendFrame(29'h302, 1'b1, 64'hD8, '0);
    // R7: FIFO wins over a matching mailbox
    clearFlags();
    fifoEn = 1'b1; fifoId = 29'h300; fifoIde = 1'b1;
    sendFrame(29'h302, 1'b1, 64'hE9, '0);
    chk("R7 no flag from FIFO", 64'(mbFlag), 64'd0);
    // R8: full FIFO falls through to the mailbox
    fifoFull = 1'b1;
    sendFrame(29'h302, 1'b1, 64'hEA, '0);
    chk("R8 mailbox took frame", 64'(mbFlag[5]), 64'd1);
    // R9: set and clear on the same edge
    setMb(1, 4'h4, 29'h400, 1'b0, '1);
    fifoEn = 1'b0;
    sendFrame(29'h400, 1'b0, 64'hF0, '0);
    sendFrame(29'h302, 1'b1, 64'hF1, '1);
    chk("R9 set wins over clear", 64'(mbFlag), 64'h20);

    // Random phase
    clearFlags();
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < NUM_MB; i++) begin
        logic [3:0] c;
        case ($urandom % 4)
          0: c = 4'h4;
          1: c = 4'h2;
          2: c = 4'h8;
          default: c = 4'h0;
        endcase
        setMb(i, c, {26'h155, 3'($urandom)}, (($urandom % 4) == 0),
              ID_W'($urandom) | ~29'h7);
      end
      globalMask = ID_W'($urandom) | ~29'h7;
      indMaskEn = 1'($urandom);
      fifoEn = 1'($urandom);
      fifoFull = 1'($urandom);
      fifoId = {26'h155, 3'($urandom)};
      fifoIde = (($urandom % 4) == 0);
      fifoMask = ID_W'($urandom) | ~29'h7;
      sendFrame({26'h155, 3'($urandom)}, (($urandom % 4) == 0),
                {$urandom, $urandom}, ((n % 7) == 0) ? NUM_MB'($urandom) : '0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule